// File: doc/BRIEF.md
# Receive Byte Ordering Realigner

This block follows a receive deserializer that packs two symbols into each word. Reset timing in the deserializer is not deterministic, so the first symbol of the stream can arrive in either lane. The block compares each word with a programmed ordering symbol. When that symbol shows up in the upper lane instead of the lower lane, the block inserts one programmable pad symbol into the stream. This shifts everything after it by one lane, so the ordering symbol and every later symbol sit in the lanes the transmitter intended.

A mode input chooses what arms the search. In automatic mode the search runs whenever the word-alignment status input is high. In manual mode, one rising edge of an enable input allows one ordering operation. A flag output pulses in the same cycle as the output word that carries the pad. The symbol width is a parameter, so the same block serves plain 8-bit data, decoded 9-bit data (8 data bits plus a control bit) and undecoded 10-bit data. Two match rules are available: the block can match on one ordering symbol, or it can require two ordering symbols in a row.

Top module: `rx_lane_order_fixer`

## Requirements
- R1: Lane 0 is bits [SYM_W-1:0] of a word and is the earlier symbol. Lane 1 is the upper SYM_W bits. With no lane offset and no ordering operation, each valid input word appears unchanged on `out_data` one clock later, with `out_valid` high and `ord_flag` low. This includes a word whose lane 0 holds the ordering symbol.
- R2: With single match (`dual_sym`=0), an ordering operation happens on a word whose lane 1 equals `ord_sym` and whose lane 0 does not, provided the trigger is active and no offset is in effect. That output word is {lane 1 = `pad_sym`, lane 0 = the word's own lane 0}, and `ord_flag` is high in that same cycle.
- R3: After an ordering operation, each valid output word is {lane 1 = lane 0 of the current word, lane 0 = lane 1 of the previous valid word}. The ordering symbol therefore appears in lane 0 of the next valid output. This offset lasts until reset. While it is in effect, no further pad is inserted.
- R4: In automatic mode (`auto_mode`=1), an operation needs `align_ok` high in the cycle in which the word appears at the output. A misplaced symbol seen while `align_ok` is low passes through unchanged.
- R5: In manual mode (`auto_mode`=0), a rising edge of `man_en` arms one operation, and a pulse lasting one cycle is enough. Keeping `man_en` high does not re-arm the block. The first word that holds the pattern in either lane uses up the arming. If that word is already in order, no pad is inserted.
- R6: With two-symbol match (`dual_sym`=1), a word counts as misplaced only when its lane 1 and lane 0 of the next input word both equal `ord_sym`, its own lane 0 does not, and that next word is valid (`in_valid` high). A word counts as in order when both of its lanes equal `ord_sym`. A lone ordering symbol in lane 1 passes through unchanged.
- R7: `ord_sym` and `pad_sym` are SYM_W-bit inputs. Changing them changes which symbol is matched and which symbol is inserted.
- R8: Synchronous reset `rst` clears the lane offset and the manual arming. It also forces `out_valid` low in the cycle after reset. An enable that is still high when reset ends does not count as a rising edge. After reset, a new operation is possible.
- R9: An input word with `in_valid` low produces an output cycle with `out_valid` low and `ord_flag` low. Such a word is not used as the previous word for the lane offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is valid |
| in_data | input | 2*SYM_W | Two-symbol input word, lane 0 in the low bits |
| auto_mode | input | 1 | 1: alignment-gated automatic trigger, 0: manual enable trigger |
| align_ok | input | 1 | Word-alignment reached status |
| man_en | input | 1 | Manual ordering enable, edge-armed |
| dual_sym | input | 1 | 1: match two ordering symbols in a row, 0: match one |
| ord_sym | input | SYM_W | Ordering symbol value |
| pad_sym | input | SYM_W | Pad symbol value |
| out_valid | output | 1 | Output word is valid |
| out_data | output | 2*SYM_W | Realigned two-symbol output word |
| ord_flag | output | 1 | High in the cycle the pad symbol is output |

## Verification
The stimulus contains words with the ordering symbol in lane 0, words with it in lane 1, and words with no pattern at all. This separates the pass-through case, the pad-insertion case and the offset data path that follows an insertion. The automatic sequences switch `align_ok` low and then high around the same misplaced pattern, which shows that the trigger gates the insertion. The manual sequences cover a single-cycle enable pulse, an enable held high through reset, and arming used up by a word that is already in order, which together separate edge arming from level arming. Two-symbol sequences place a lone upper symbol, a real straddling pair, a pair broken by an invalid word, and a word with the symbol in both lanes, so each rule of the dual match is shown to matter. Changed symbol values confirm that both symbol inputs take effect.

// File: rtl/rx_lane_order_fixer.sv
module rx_lane_order_fixer #(
  parameter int SYM_W = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [2*SYM_W-1:0] in_data,
  input  logic               auto_mode,
  input  logic               align_ok,
  input  logic               man_en,
  input  logic               dual_sym,
  input  logic [SYM_W-1:0]   ord_sym,
  input  logic [SYM_W-1:0]   pad_sym,
  output logic               out_valid,
  output logic [2*SYM_W-1:0] out_data,
  output logic               ord_flag
);

  logic               s_valid;
  logic [2*SYM_W-1:0] s_word;
  logic [SYM_W-1:0]   hold;
  logic               shifted;
  logic               armed;
  logic               man_q;

  logic [SYM_W-1:0] s_lo, s_hi;
  assign s_lo = s_word[SYM_W-1:0];
  assign s_hi = s_word[2*SYM_W-1:SYM_W];

  logic hit_lo, hit_hi, hit_next;
  assign hit_lo   = (s_lo == ord_sym);
  assign hit_hi   = (s_hi == ord_sym);
  assign hit_next = in_valid && (in_data[SYM_W-1:0] == ord_sym);

  logic in_order, misplaced;
  assign in_order  = hit_lo && (!dual_sym || hit_hi);
  assign misplaced = hit_hi && !hit_lo && (!dual_sym || hit_next);

  logic man_req, trig, looking, op;
  assign man_req = armed || (man_en && !man_q);
  assign trig    = auto_mode ? align_ok : man_req;
  assign looking = s_valid && !shifted && !rst;
  assign op      = looking && trig && misplaced;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_valid <= 1'b0;
      s_word  <= '0;
      hold    <= '0;
      shifted <= 1'b0;
      armed   <= 1'b0;
      man_q   <= 1'b1;
    end else begin
      s_valid <= in_valid;
      if (in_valid) s_word <= in_data;
      if (s_valid)  hold   <= s_hi;
      if (op)       shifted <= 1'b1;
      man_q <= man_en;
      armed <= !auto_mode && man_req && !(looking && (in_order || misplaced));
    end
  end

  assign out_valid = s_valid;
  assign ord_flag  = op;

  always_comb begin
    if (op)           out_data = {pad_sym, s_lo};
    else if (shifted) out_data = {s_lo, hold};
    else              out_data = s_word;
  end

  AST_FLAG_HAS_WORD: assert property (@(posedge clk) disable iff (rst)
    ord_flag |-> out_valid); // R9
  AST_FLAG_ONCE: assert property (@(posedge clk) disable iff (rst)
    ord_flag |=> !ord_flag); // R3
  AST_ORD_LANDS_LOW: assert property (@(posedge clk) disable iff (rst)
    ord_flag |=> (!out_valid || out_data[SYM_W-1:0] == $past(ord_sym))); // R3
  AST_AUTO_NEEDS_ALIGN: assert property (@(posedge clk) disable iff (rst)
    (ord_flag && auto_mode) |-> align_ok); // R4
  AST_DUAL_NEEDS_NEXT: assert property (@(posedge clk) disable iff (rst)
    (ord_flag && dual_sym) |-> (in_valid && in_data[SYM_W-1:0] == ord_sym)); // R6
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!out_valid && !ord_flag)); // R8

endmodule

// File: tb/test_rx_lane_order_fixer.sv
`timescale 1ns/1ps
module test_rx_lane_order_fixer;
  localparam int W = 10;
  localparam int O = 'h1BC;
  localparam int P = 'h0F7;

  typedef struct packed {
    int rst; int v; int lo; int hi; int al; int men; int am; int dl;
    int ev; int elo; int ehi; int ef; int req;
  } vec_t;

  // Expectations of row i describe the word driven in row i-1.
  localparam int NV = 39;
  localparam vec_t TBL [NV] = '{
    '{0,1,1,2,0,0,1,0,  0,0,0,0, 8},   // R8 first word after reset
    '{0,1,O,3,1,0,1,0,  1,1,2,0, 1},   // R1 no pattern
    '{0,1,4,O,0,0,1,0,  1,O,3,0, 1},   // R1 symbol already in lane 0
    '{0,1,5,6,0,0,1,0,  1,4,O,0, 4},   // R4 misplaced but align_ok low
    '{0,1,7,O,1,0,1,0,  1,5,6,0, 1},
    '{0,1,8,9,1,0,1,0,  1,7,P,1, 2},   // R2 pad inserted
    '{0,0,0,0,1,0,1,0,  1,O,8,0, 3},   // R3 offset path
    '{0,1,10,O,1,0,1,0, 0,0,0,0, 9},   // R9 invalid word
    '{0,1,11,12,1,0,1,0,1,9,10,0,3},   // R3 no second pad
    '{0,1,13,14,1,0,1,0,1,O,11,0,3},
    '{1,1,1,2,1,0,1,0,  1,12,13,0,3},  // R3 offset held into reset cycle
    '{0,1,5,O,1,0,1,0,  0,0,0,0, 8},   // R8 valid low after reset
    '{0,1,O,1,1,0,1,0,  1,5,P,1, 8},   // R8 offset cleared, new op
    '{0,1,2,3,1,0,1,0,  1,O,O,0, 3},
    '{1,0,0,0,0,0,0,0,  1,1,2,0, 3},
    '{0,1,4,O,0,0,0,0,  0,0,0,0, 8},
    '{0,1,1,2,0,0,0,0,  1,4,O,0, 5},   // R5 not armed
    '{0,1,3,O,0,1,0,0,  1,1,2,0, 5},   // R5 one-cycle pulse
    '{0,1,5,6,0,0,0,0,  1,3,P,1, 5},   // R5 armed op
    '{1,0,0,0,0,1,0,0,  1,O,5,0, 3},
    '{0,1,7,O,0,1,0,0,  0,0,0,0, 8},
    '{0,1,8,9,0,1,0,0,  1,7,O,0, 5},   // R5 held enable does not arm
    '{0,1,O,1,0,0,0,0,  1,8,9,0, 5},
    '{0,1,2,3,0,1,0,0,  1,O,1,0, 5},   // R5 arming used by in-order word
    '{0,1,4,O,0,1,0,0,  1,2,3,0, 5},
    '{0,1,5,6,0,1,0,0,  1,4,O,0, 5},   // R5 arming consumed
    '{1,0,0,0,1,0,1,1,  1,5,6,0, 8},
    '{0,1,1,O,1,0,1,1,  0,0,0,0, 8},
    '{0,1,2,3,1,0,1,1,  1,1,O,0, 6},   // R6 lone symbol ignored
    '{0,1,4,O,1,0,1,1,  1,2,3,0, 6},
    '{0,1,O,5,1,0,1,1,  1,4,P,1, 6},   // R6 pair straddles words
    '{0,1,6,7,1,0,1,1,  1,O,O,0, 3},
    '{1,0,0,0,1,0,1,1,  1,5,6,0, 3},
    '{0,1,O,O,1,0,1,1,  0,0,0,0, 8},
    '{0,1,O,8,1,0,1,1,  1,O,O,0, 6},   // R6 both lanes: in order
    '{0,1,9,9,1,0,1,1,  1,O,8,0, 6},
    '{0,1,1,O,1,0,1,1,  1,9,9,0, 6},
    '{0,0,O,O,1,0,1,1,  1,1,O,0, 6},   // R6 next word invalid
    '{0,1,2,3,1,0,1,1,  0,0,0,0, 9}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [2*W-1:0] in_data = '0;
  logic auto_mode = 1'b1, align_ok = 1'b0, man_en = 1'b0, dual_sym = 1'b0;
  logic [W-1:0] ord_sym = W'(O);
  logic [W-1:0] pad_sym = W'(P);
  logic out_valid, ord_flag;
  logic [2*W-1:0] out_data;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rx_lane_order_fixer #(.SYM_W(W)) i_rx_lane_order_fixer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .auto_mode(auto_mode), .align_ok(align_ok), .man_en(man_en),
    .dual_sym(dual_sym), .ord_sym(ord_sym), .pad_sym(pad_sym),
    .out_valid(out_valid), .out_data(out_data), .ord_flag(ord_flag));

  task automatic do_row(input vec_t t, input int idx);
    int alo, ahi;
    bit bad;
    @(negedge clk);
    rst = t.rst[0]; in_valid = t.v[0];
    in_data = {t.hi[W-1:0], t.lo[W-1:0]};
    align_ok = t.al[0]; man_en = t.men[0]; auto_mode = t.am[0]; dual_sym = t.dl[0];
    #1;
    alo = int'(out_data[W-1:0]);
    ahi = int'(out_data[2*W-1:W]);
    checks++;
    bad = (int'(out_valid) != t.ev);
    if (t.ev != 0) bad = bad || alo != t.elo || ahi != t.ehi || int'(ord_flag) != t.ef;
    else bad = bad || ord_flag;
    if (bad) begin
      fails++;
      $display("FAIL R%0d row %0d: valid/lo/hi/flag %0d/%h/%h/%0d expected %0d/%h/%h/%0d",
               t.req, idx, out_valid, alo, ahi, ord_flag, t.ev, t.elo, t.ehi, t.ef);
    end
  endtask

  initial begin
    in_valid = 1'b1; in_data = {W'(O), W'(1)};
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    checks++; // R8 reset state
    if (out_valid !== 1'b0 || ord_flag !== 1'b0) begin
      fails++;
      $display("FAIL R8 reset: valid %0d flag %0d expected 0 0", out_valid, ord_flag);
    end
    for (int i = 0; i < NV; i++) do_row(TBL[i], i);
    // R7 directed: new symbol values
    ord_sym = W'('h055); pad_sym = W'('h2AA);
    do_row(vec_t'{1,0,0,0,1,0,1,0, 1,2,3,0, 7}, 100);
    do_row(vec_t'{0,1,'h11,O,1,0,1,0, 0,0,0,0, 7}, 101);
    do_row(vec_t'{0,1,'h12,'h055,1,0,1,0, 1,'h11,O,0, 7}, 102);
    do_row(vec_t'{0,1,'h13,'h14,1,0,1,0, 1,'h12,'h2AA,1, 7}, 103);
    do_row(vec_t'{0,0,0,0,1,0,1,0, 1,'h055,'h13,0, 7}, 104);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (R1): run state hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule